// File: doc/BRIEF.md
# Slot Hot-Plug Event Controller

This block holds the hot-plug portion of a downstream port's slot registers: a control word and a status word. Both sit in one dword of a register-write interface made of an address, four byte enables and 32 data bits. The control word occupies bytes 0 and 1 and the status word bytes 2 and 3. Physical slot events are single-cycle strobes that set sticky status bits. The events are attention button press, power fault, latch sensor change, link-state change, device present at cold start, hot insertion and removal. Software clears these bits by writing ones to them.

The block derives a single notification condition from the enables and the pending events, and keeps a registered copy of it. A request goes out only when a newly computed condition differs from the stored copy. It is delivered as an MSI-X request when MSI-X is enabled, as an MSI request when MSI is enabled, and otherwise as a level on a selected legacy interrupt line. Every write that touches the control bytes counts as one command and completes at once, which sets the command-completed event. Writing 1 to the interlock control bit flips the interlock status bit and is not stored.

Top module: `hp_slot_ctrl`

## Requirements
- R1: While reset is active, and after it is released, control and status read 0x0000, both request valids are low and every INTx line is low.
- R2: The condition is true when control bit 5 is set and at least one event is both pending and enabled. The event/enable pairs are status bit 0 with control bit 0, bit 1 with 1, bit 2 with 2, bit 3 with 3, bit 4 with 4, and status bit 8 with control bit 12. With both message types disabled, the INTx line chosen by `intx_sel` follows the stored condition, and all other lines stay low.
- R3: A request is raised only in the cycle after the stored condition changes value (either direction); an update that leaves the condition unchanged raises none.
- R4: Delivery priority is MSI-X (when `msix_en`), else MSI (when `msi_en`), else INTx; while either message type is enabled all INTx lines are low.
- R5: An event raised while its enable or the interrupt enable is off is held, and the condition turns true as soon as a later control write enables it.
- R6: Raising an event whose status bit is already set changes nothing and produces no request.
- R7: A write to address `SLOT_ADDR` with `wr_be[1:0]` nonzero updates the control bytes it enables and sets status bit 4 (command completed) in the same cycle. A write to status bytes only, or to any other address, sets no completion.
- R8: Control bit 11 always reads 0. A control write with `wr_be[1]` set and data bit 11 = 1 inverts status bit 7.
- R9: A cold-start presence strobe sets status bit 6 only. A hot insertion sets bit 6 and bit 3. A removal clears bit 6 and sets bit 3.
- R10: Writing 1 to status bits 0–4 or 8 through bytes 2–3 (data bits 16–20, 24) clears them. Ones written to bits 6 and 7 have no effect.
- R11: Events arriving in the same cycle as a write are applied after the write, so an event wins over a clear of the same bit; the condition is evaluated once from the combined result.
- R12: A request valid stays high until its ready is seen high, and drops in the cycle after the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte address of the written dword |
| wr_be | input | 4 | Byte enables (0–1 control, 2–3 status) |
| wr_data | input | 32 | Write data |
| ev_attn | input | 1 | Attention button pressed strobe |
| ev_pwr_fault | input | 1 | Power fault strobe |
| ev_latch_chg | input | 1 | Retention latch sensor changed strobe |
| ev_link_chg | input | 1 | Link-layer state changed strobe |
| dev_coldplug | input | 1 | Device present at cold start strobe |
| dev_insert | input | 1 | Hot insertion strobe |
| dev_remove | input | 1 | Removal strobe |
| msix_en | input | 1 | MSI-X delivery enabled |
| msi_en | input | 1 | MSI delivery enabled |
| intx_sel | input | SEL_W | Which legacy line carries the level |
| msix_req_valid | output | 1 | MSI-X request |
| msix_req_ready | input | 1 | MSI-X request accepted |
| msi_req_valid | output | 1 | MSI request |
| msi_req_ready | input | 1 | MSI request accepted |
| intx_o | output | INTX_LINES | Legacy interrupt levels |
| slot_ctl | output | 16 | Control word read value |
| slot_sts | output | 16 | Status word read value |

## Verification
The bench builds the block with its defaults: all six event types supported, four legacy lines and the slot dword at byte address 0x18. With the full event mask every event/enable pairing, including the link-state pair that is split across byte lanes, can reach the condition. With four lines, a nonzero line select can be told apart from line 0. A table walks the register and presence sequence in INTx mode. Directed steps then switch on MSI and MSI-X, stall the ready, and repeat resets for the cold-start case.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;

  localparam int NEV = 6;

  localparam int ST_ATTN  = 0;
  localparam int ST_PWRF  = 1;
  localparam int ST_LATCH = 2;
  localparam int ST_PCHG  = 3;
  localparam int ST_CMPL  = 4;
  localparam int ST_PRES  = 6;
  localparam int ST_LOCK  = 7;
  localparam int ST_LINK  = 8;

  localparam int CT_IRQEN = 5;
  localparam int CT_LOCK  = 11;
  localparam int CT_LINK  = 12;

  localparam logic [15:0] CTL_KEEP = 16'h17FF;
  localparam logic [15:0] STS_W1C  = 16'h011F;

  function automatic logic [NEV-1:0] sts_events(input logic [15:0] s);
    return {s[ST_LINK], s[ST_CMPL:ST_ATTN]};
  endfunction

  function automatic logic [NEV-1:0] ctl_enables(input logic [15:0] c);
    return {c[CT_LINK], c[4:0]};
  endfunction

endpackage

// File: rtl/hp_rst_sync.sv
module hp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/hp_slot_regs.sv
module hp_slot_regs
  import hp_slot_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_wr,
  input  logic        sts_wr,
  input  logic [3:0]  wr_be,
  input  logic [31:0] wr_data,
  input  logic        ev_attn,
  input  logic        ev_pwr_fault,
  input  logic        ev_latch_chg,
  input  logic        ev_link_chg,
  input  logic        dev_coldplug,
  input  logic        dev_insert,
  input  logic        dev_remove,
  output logic [15:0] ctl_q,
  output logic [15:0] sts_q,
  output logic [15:0] ctl_nxt,
  output logic [15:0] sts_nxt
);
  logic [15:0] ctl_merged;
  logic [15:0] w1c_bits;
  logic        any_ev;
  logic        ctl_en;
  logic        sts_en;

  always_comb begin
    ctl_merged[7:0]  = wr_be[0] ? wr_data[7:0]  : ctl_q[7:0];
    ctl_merged[15:8] = wr_be[1] ? wr_data[15:8] : ctl_q[15:8];
    w1c_bits[7:0]    = wr_be[2] ? wr_data[23:16] : 8'h00;
    w1c_bits[15:8]   = wr_be[3] ? wr_data[31:24] : 8'h00;
    w1c_bits         = w1c_bits & STS_W1C;
  end

  always_comb begin
    ctl_nxt = ctl_q;
    sts_nxt = sts_q;
    // the write is applied first
    if (ctl_wr) begin
      ctl_nxt = ctl_merged & CTL_KEEP;
      if (wr_be[1] && wr_data[CT_LOCK]) sts_nxt[ST_LOCK] = ~sts_q[ST_LOCK];
    end
    if (sts_wr) sts_nxt = sts_nxt & ~w1c_bits;
    // then events set their bits on top of it
    if (ev_attn)      sts_nxt[ST_ATTN]  = 1'b1;
    if (ev_pwr_fault) sts_nxt[ST_PWRF]  = 1'b1;
    if (ev_latch_chg) sts_nxt[ST_LATCH] = 1'b1;
    if (ev_link_chg)  sts_nxt[ST_LINK]  = 1'b1;
    if (dev_coldplug) sts_nxt[ST_PRES]  = 1'b1;
    if (dev_insert) begin
      sts_nxt[ST_PRES] = 1'b1;
      sts_nxt[ST_PCHG] = 1'b1;
    end
    if (dev_remove) begin
      sts_nxt[ST_PRES] = 1'b0;
      sts_nxt[ST_PCHG] = 1'b1;
    end
    if (ctl_wr) sts_nxt[ST_CMPL] = 1'b1;
  end

  assign any_ev = ev_attn | ev_pwr_fault | ev_latch_chg | ev_link_chg |
                  dev_coldplug | dev_insert | dev_remove;
  assign ctl_en = ctl_wr;
  assign sts_en = ctl_wr | sts_wr | any_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= 16'h0000;
    else if (ctl_en) ctl_q <= ctl_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sts_q <= 16'h0000;
    else if (sts_en) sts_q <= sts_nxt;
  end

  // R7: a control command always completes in the same step
  a_r7_cmd_done: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> sts_q[ST_CMPL]);

  // R8: interlock request inverts the interlock status
  a_r8_lock_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wr_be[1] && wr_data[CT_LOCK]) |=> (sts_q[ST_LOCK] != $past(sts_q[ST_LOCK])));

  // R9: hot insertion reports presence and a presence change
  a_r9_insert: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_insert && !dev_remove) |=> (sts_q[ST_PRES] && sts_q[ST_PCHG]));

  // R6: nothing moves the status word without a write or an event
  a_r6_status_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_wr && !sts_wr && !any_ev) |=> $stable(sts_q));
endmodule

// File: rtl/hp_slot_notify.sv
module hp_slot_notify
  import hp_slot_pkg::*;
#(
  parameter logic [NEV-1:0] EV_MASK    = '1,
  parameter int             INTX_LINES = 4,
  localparam int            SEL_W      = (INTX_LINES > 1) ? $clog2(INTX_LINES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [15:0]           ctl_nxt,
  input  logic [15:0]           sts_nxt,
  input  logic                  msix_en,
  input  logic                  msi_en,
  input  logic [SEL_W-1:0]      intx_sel,
  input  logic                  msix_req_ready,
  input  logic                  msi_req_ready,
  output logic                  msix_req_valid,
  output logic                  msi_req_valid,
  output logic [INTX_LINES-1:0] intx_o
);
  logic cond_nxt;
  logic flag_q;
  logic change;
  logic msix_v_d;
  logic msi_v_d;
  logic intx_lvl;

  always_comb begin
    cond_nxt = ctl_nxt[CT_IRQEN] &&
               (|(sts_events(sts_nxt) & ctl_enables(ctl_nxt) & EV_MASK));
    change   = cond_nxt != flag_q;
    msix_v_d = (msix_req_valid && !msix_req_ready) || (change && msix_en);
    msi_v_d  = (msi_req_valid && !msi_req_ready) || (change && !msix_en && msi_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (change) flag_q <= cond_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msix_req_valid <= 1'b0;
      msi_req_valid  <= 1'b0;
    end else begin
      msix_req_valid <= msix_v_d;
      msi_req_valid  <= msi_v_d;
    end
  end

  assign intx_lvl = flag_q && !msix_en && !msi_en;

  for (genvar i = 0; i < INTX_LINES; i++) begin : g_intx
    assign intx_o[i] = intx_lvl && (intx_sel == SEL_W'(i));
  end

  // R3: a change seen under MSI-X raises its request
  a_r3_msix_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q != $past(flag_q)) && $past(msix_en)) |-> msix_req_valid);

  // R3: no request appears without a change of the stored condition
  a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(msix_req_valid) || $rose(msi_req_valid)) |-> (flag_q != $past(flag_q)));

  // R12: a pending request waits for its ready
  a_r12_msix_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (msix_req_valid && !msix_req_ready) |=> msix_req_valid);

  a_r12_msi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_req_valid && !msi_req_ready) |=> msi_req_valid);

  // R2: at most one legacy line is driven
  a_r2_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(intx_o));
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_slot_pkg::*;
#(
  parameter int             ADDR_W     = 8,
  parameter logic [7:0]     SLOT_ADDR  = 8'h18,
  parameter logic [NEV-1:0] EV_MASK    = '1,
  parameter int             INTX_LINES = 4,
  localparam int            SEL_W      = (INTX_LINES > 1) ? $clog2(INTX_LINES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [3:0]            wr_be,
  input  logic [31:0]           wr_data,
  input  logic                  ev_attn,
  input  logic                  ev_pwr_fault,
  input  logic                  ev_latch_chg,
  input  logic                  ev_link_chg,
  input  logic                  dev_coldplug,
  input  logic                  dev_insert,
  input  logic                  dev_remove,
  input  logic                  msix_en,
  input  logic                  msi_en,
  input  logic [SEL_W-1:0]      intx_sel,
  output logic                  msix_req_valid,
  input  logic                  msix_req_ready,
  output logic                  msi_req_valid,
  input  logic                  msi_req_ready,
  output logic [INTX_LINES-1:0] intx_o,
  output logic [15:0]           slot_ctl,
  output logic [15:0]           slot_sts
);
  logic        rst_sync_n;
  logic        hit;
  logic        ctl_wr;
  logic        sts_wr;
  logic [15:0] ctl_nxt;
  logic [15:0] sts_nxt;

  hp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign hit    = wr_en && (wr_addr == ADDR_W'(SLOT_ADDR));
  assign ctl_wr = hit && (|wr_be[1:0]);
  assign sts_wr = hit && (|wr_be[3:2]);

  hp_slot_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .ctl_wr       (ctl_wr),
    .sts_wr       (sts_wr),
    .wr_be        (wr_be),
    .wr_data      (wr_data),
    .ev_attn      (ev_attn),
    .ev_pwr_fault (ev_pwr_fault),
    .ev_latch_chg (ev_latch_chg),
    .ev_link_chg  (ev_link_chg),
    .dev_coldplug (dev_coldplug),
    .dev_insert   (dev_insert),
    .dev_remove   (dev_remove),
    .ctl_q        (slot_ctl),
    .sts_q        (slot_sts),
    .ctl_nxt      (ctl_nxt),
    .sts_nxt      (sts_nxt)
  );

  hp_slot_notify #(
    .EV_MASK    (EV_MASK),
    .INTX_LINES (INTX_LINES)
  ) u_notify (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .ctl_nxt        (ctl_nxt),
    .sts_nxt        (sts_nxt),
    .msix_en        (msix_en),
    .msi_en         (msi_en),
    .intx_sel       (intx_sel),
    .msix_req_ready (msix_req_ready),
    .msi_req_ready  (msi_req_ready),
    .msix_req_valid (msix_req_valid),
    .msi_req_valid  (msi_req_valid),
    .intx_o         (intx_o)
  );

  // R8: the interlock control bit never reads back as 1
  a_r8_lock_reads_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !slot_ctl[CT_LOCK]);
endmodule

// File: tb/hp_slot_ctrl_tb.sv
module hp_slot_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [3:0]  wr_be;
  logic [31:0] wr_data;
  logic        ev_attn, ev_pwr_fault, ev_latch_chg, ev_link_chg;
  logic        dev_coldplug, dev_insert, dev_remove;
  logic        msix_en, msi_en;
  logic [1:0]  intx_sel;
  logic        msix_req_valid, msix_req_ready, msi_req_valid, msi_req_ready;
  logic [3:0]  intx_o;
  logic [15:0] slot_ctl, slot_sts;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  hp_slot_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
    .wr_data(wr_data), .ev_attn(ev_attn), .ev_pwr_fault(ev_pwr_fault),
    .ev_latch_chg(ev_latch_chg), .ev_link_chg(ev_link_chg),
    .dev_coldplug(dev_coldplug), .dev_insert(dev_insert), .dev_remove(dev_remove),
    .msix_en(msix_en), .msi_en(msi_en), .intx_sel(intx_sel),
    .msix_req_valid(msix_req_valid), .msix_req_ready(msix_req_ready),
    .msi_req_valid(msi_req_valid), .msi_req_ready(msi_req_ready),
    .intx_o(intx_o), .slot_ctl(slot_ctl), .slot_sts(slot_sts)
  );

  // ev bits: [0] attn [1] power fault [2] latch [3] link [4] insert [5] remove
  typedef struct packed {
    logic        we;
    logic [3:0]  be;
    logic [31:0] d;
    logic [5:0]  ev;
    logic [15:0] ectl;
    logic [15:0] ests;
    logic        eint;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 4'h0, 32'h0000_0000, 6'h01, 16'h0000, 16'h0001, 1'b0}, // R5 event held while blocked
    '{1'b1, 4'h3, 32'h0000_0021, 6'h00, 16'h0021, 16'h0011, 1'b1}, // R5 R7 R2 enable makes it true
    '{1'b0, 4'h0, 32'h0000_0000, 6'h01, 16'h0021, 16'h0011, 1'b1}, // R6 repeat event
    '{1'b1, 4'hC, 32'h0001_0000, 6'h00, 16'h0021, 16'h0010, 1'b0}, // R10 clear attn
    '{1'b1, 4'h3, 32'h0000_0830, 6'h00, 16'h0030, 16'h0090, 1'b1}, // R8 lock flip
    '{1'b1, 4'hC, 32'hFFFF_0000, 6'h00, 16'h0030, 16'h0080, 1'b0}, // R10 bits 6,7 immune
    '{1'b0, 4'h0, 32'h0000_0000, 6'h10, 16'h0030, 16'h00C8, 1'b0}, // R9 insertion
    '{1'b1, 4'h3, 32'h0000_0838, 6'h01, 16'h0038, 16'h0059, 1'b1}, // R11 R8 write plus event
    '{1'b1, 4'hC, 32'h0018_0000, 6'h00, 16'h0038, 16'h0041, 1'b0}, // R10 clear two
    '{1'b0, 4'h0, 32'h0000_0000, 6'h20, 16'h0038, 16'h0009, 1'b1}, // R9 removal
    '{1'b1, 4'hC, 32'h0009_0000, 6'h20, 16'h0038, 16'h0008, 1'b1}, // R11 event beats clear
    '{1'b1, 4'h3, 32'h0000_0000, 6'h00, 16'h0000, 16'h0018, 1'b0}, // R2 irq enable off
    '{1'b0, 4'h0, 32'h0000_0000, 6'h08, 16'h0000, 16'h0118, 1'b0}, // R5 link event held
    '{1'b1, 4'h3, 32'h0000_1020, 6'h00, 16'h1020, 16'h0118, 1'b1}, // R2 link pair bit8/bit12
    '{1'b1, 4'h4, 32'h00FF_0000, 6'h00, 16'h1020, 16'h0100, 1'b1}  // R7 R10 status-only write
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    wr_en = 1'b0; wr_addr = 8'h18; wr_be = 4'h0; wr_data = 32'h0;
    ev_attn = 1'b0; ev_pwr_fault = 1'b0; ev_latch_chg = 1'b0; ev_link_chg = 1'b0;
    dev_coldplug = 1'b0; dev_insert = 1'b0; dev_remove = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    #2;
    idle_inputs();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #5;
    check("R1 ctl in reset", {16'h0, slot_ctl}, 32'h0);
    check("R1 sts in reset", {16'h0, slot_sts}, 32'h0);
    check("R1 outputs in reset", {29'h0, msix_req_valid, msi_req_valid, |intx_o}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle_inputs();
    msix_en = 1'b0; msi_en = 1'b0; intx_sel = 2'd0;
    msix_req_ready = 1'b1; msi_req_ready = 1'b1;
    do_reset();
    check("R1 ctl after reset", {16'h0, slot_ctl}, 32'h0);
    check("R1 sts after reset", {16'h0, slot_sts}, 32'h0);

    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      wr_en = TBL[i].we; wr_be = TBL[i].be; wr_data = TBL[i].d;
      ev_attn = TBL[i].ev[0]; ev_pwr_fault = TBL[i].ev[1];
      ev_latch_chg = TBL[i].ev[2]; ev_link_chg = TBL[i].ev[3];
      dev_insert = TBL[i].ev[4]; dev_remove = TBL[i].ev[5];
      step();
      check($sformatf("R7 R8 ctl row %0d", i), {16'h0, slot_ctl}, {16'h0, TBL[i].ectl});
      check($sformatf("R9 R10 R11 sts row %0d", i), {16'h0, slot_sts}, {16'h0, TBL[i].ests});
      check($sformatf("R2 intx row %0d", i), {28'h0, intx_o}, {31'h0, TBL[i].eint});
      check($sformatf("R4 no message row %0d", i), {30'h0, msix_req_valid, msi_req_valid}, 32'h0);
    end

    // R2: line select moves the level
    intx_sel = 2'd2;
    #1;
    check("R2 line select", {28'h0, intx_o}, 32'h4);
    intx_sel = 2'd0;

    // R4: MSI takes over, INTx falls quiet
    msi_en = 1'b1;
    #1;
    check("R4 intx quiet under msi", {28'h0, intx_o}, 32'h0);
    wr_en = 1'b1; wr_be = 4'h8; wr_data = 32'h0100_0000;
    step();
    check("R3 R4 msi on falling change", {30'h0, msix_req_valid, msi_req_valid}, 32'h1);
    check("R10 link cleared", {16'h0, slot_sts}, 32'h0);
    step();
    check("R12 msi drops after handshake", {31'h0, msi_req_valid}, 32'h0);

    // R4 R12: MSI-X wins and waits for ready
    msix_en = 1'b1; msix_req_ready = 1'b0;
    ev_link_chg = 1'b1;
    step();
    check("R4 msix chosen", {30'h0, msix_req_valid, msi_req_valid}, 32'h2);
    step();
    check("R12 msix held 1", {31'h0, msix_req_valid}, 32'h1);
    step();
    check("R12 msix held 2", {31'h0, msix_req_valid}, 32'h1);
    msix_req_ready = 1'b1;
    step();
    check("R12 msix released", {31'h0, msix_req_valid}, 32'h0);

    // R6 R3: repeating a set event gives no request
    ev_link_chg = 1'b1;
    step();
    check("R6 no request on repeat", {30'h0, msix_req_valid, msi_req_valid}, 32'h0);
    check("R6 status unchanged", {16'h0, slot_sts}, 32'h0100);

    // R7: write to another address is ignored
    wr_en = 1'b1; wr_addr = 8'h1C; wr_be = 4'h3; wr_data = 32'h0;
    step();
    check("R7 other address ctl", {16'h0, slot_ctl}, 32'h1020);
    check("R7 other address sts", {16'h0, slot_sts}, 32'h0100);

    // R9: cold-start presence
    msix_en = 1'b0; msi_en = 1'b0;
    do_reset();
    check("R1 outputs after second reset", {29'h0, msix_req_valid, msi_req_valid, |intx_o}, 32'h0);
    dev_coldplug = 1'b1;
    step();
    check("R9 coldplug presence only", {16'h0, slot_sts}, 32'h0040);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule